// File: doc/BRIEF.md
# Mailbox Channel State Tracker with Host Interrupts

This block keeps the handshake state of a two-way mailbox shared by a host and a coprocessor. There are seven channels in each direction. Outbound traffic runs on send channels and inbound traffic runs on receive channels. Each channel carries one message at a time and has a two-bit state. The message bodies are held elsewhere, one 32-byte slot per channel at base plus channel times 32. This block stores only the states, accepts state writes from both sides, and turns selected state entries into two sticky host interrupt flags.

On a send channel the host posts NEW. The coprocessor then moves the state to RCVD and later to COMPLETE. The host reads the reply and returns the state to IDLE. A receive channel runs the same cycle with the roles swapped: the coprocessor posts NEW, the host moves it through RCVD and COMPLETE, and the coprocessor returns it to IDLE.

The done flag rises when a send channel enters COMPLETE. The arrival flag rises when a receive channel enters NEW. The host clears each flag with a one-cycle pulse. Two seven-bit masks show, at any time, which send channels are COMPLETE and which receive channels are NEW.

Top module: `mbox_state_irq`

## Requirements
- R1: After reset every channel state in both directions reads IDLE, both interrupt flags are 0 and both masks are 0.
- R2: A write strobe from either side, with direction select (0 = send, 1 = receive), channel index and 2-bit value (IDLE=0, NEW=1, RCVD=2, COMPLETE=3), stores the value at the next clock edge. The read port returns the stored state of the selected channel combinationally.
- R3: A write whose channel index is 7 or higher changes no state and raises no flag. Reading such an index returns 0.
- R4: If host and coprocessor write the same channel of the same direction in the same cycle, the coprocessor's value is stored.
- R5: `done_irq` becomes 1 at the clock edge where any send channel changes from a value other than COMPLETE (3) to COMPLETE.
- R6: `arrival_irq` becomes 1 at the clock edge where any receive channel changes from a value other than NEW (1) to NEW.
- R7: Writing a channel with the value it already holds does not set a flag again.
- R8: A flag stays 1 until the matching host clear pulse, which clears it at the next edge. If a new entry occurs in the same cycle as the clear, the flag stays 1.
- R9: Bit c of `done_mask` is 1 exactly when send channel c holds COMPLETE. Bit c of `arrival_mask` is 1 exactly when receive channel c holds NEW.
- R10: The flags are direction-specific. A receive channel entering COMPLETE does not set `done_irq`, and a send channel entering NEW does not set `arrival_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_we | input | 1 | Host state write strobe |
| h_dir | input | 1 | Host write direction (0 send, 1 receive) |
| h_ch | input | 3 | Host write channel |
| h_val | input | 2 | Host write state value |
| c_we | input | 1 | Coprocessor state write strobe |
| c_dir | input | 1 | Coprocessor write direction |
| c_ch | input | 3 | Coprocessor write channel |
| c_val | input | 2 | Coprocessor write state value |
| clr_done | input | 1 | Host clear pulse for done_irq |
| clr_arrival | input | 1 | Host clear pulse for arrival_irq |
| rd_dir | input | 1 | Read port direction |
| rd_ch | input | 3 | Read port channel |
| rd_val | output | 2 | State of the selected channel |
| done_irq | output | 1 | Sticky flag: a send channel entered COMPLETE |
| arrival_irq | output | 1 | Sticky flag: a receive channel entered NEW |
| done_mask | output | 7 | Send channels currently COMPLETE |
| arrival_mask | output | 7 | Receive channels currently NEW |

## Verification
The assertions assume that every input is driven to a known value from the first clock edge onward. They also assume that a channel's state changes only through the two write ports, so any new bit in a mask must line up with a flag set at the same edge. The bench drives every strobe and clear low on idle cycles and changes inputs only on the falling edge. It uses out-of-range indices only in the test written for them.

// File: rtl/mbox_state_irq.sv
module mbox_state_irq #(
  parameter int NCH = 7,
  parameter int CW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_we,
  input  logic           h_dir,
  input  logic [CW-1:0]  h_ch,
  input  logic [1:0]     h_val,
  input  logic           c_we,
  input  logic           c_dir,
  input  logic [CW-1:0]  c_ch,
  input  logic [1:0]     c_val,
  input  logic           clr_done,
  input  logic           clr_arrival,
  input  logic           rd_dir,
  input  logic [CW-1:0]  rd_ch,
  output logic [1:0]     rd_val,
  output logic           done_irq,
  output logic           arrival_irq,
  output logic [NCH-1:0] done_mask,
  output logic [NCH-1:0] arrival_mask
);
  localparam logic [1:0] ST_NEW  = 2'd1;
  localparam logic [1:0] ST_DONE = 2'd3;

  logic [1:0] snd_q [NCH];
  logic [1:0] rcv_q [NCH];
  logic [1:0] snd_d [NCH];
  logic [1:0] rcv_d [NCH];
  logic [NCH-1:0] done_entry, arr_entry;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      snd_d[c] = snd_q[c];
      rcv_d[c] = rcv_q[c];
      if (h_we && h_ch == CW'(c)) begin
        if (h_dir) rcv_d[c] = h_val;
        else       snd_d[c] = h_val;
      end
      if (c_we && c_ch == CW'(c)) begin
        if (c_dir) rcv_d[c] = c_val;
        else       snd_d[c] = c_val;
      end
      done_entry[c]   = (snd_d[c] == ST_DONE) && (snd_q[c] != ST_DONE);
      arr_entry[c]    = (rcv_d[c] == ST_NEW)  && (rcv_q[c] != ST_NEW);
      done_mask[c]    = snd_q[c] == ST_DONE;
      arrival_mask[c] = rcv_q[c] == ST_NEW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        snd_q[c] <= '0;
        rcv_q[c] <= '0;
      end
      done_irq    <= 1'b0;
      arrival_irq <= 1'b0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        snd_q[c] <= snd_d[c];
        rcv_q[c] <= rcv_d[c];
      end
      if (|done_entry)   done_irq <= 1'b1;
      else if (clr_done) done_irq <= 1'b0;
      if (|arr_entry)       arrival_irq <= 1'b1;
      else if (clr_arrival) arrival_irq <= 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_ch == CW'(c)) rd_val = rd_dir ? rcv_q[c] : snd_q[c];
  end
endmodule

module mbox_state_irq_chk #(
  parameter int NCH = 7,
  parameter int CW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr_done,
  input logic           clr_arrival,
  input logic           rd_dir,
  input logic [CW-1:0]  rd_ch,
  input logic [1:0]     rd_val,
  input logic           done_irq,
  input logic           arrival_irq,
  input logic [NCH-1:0] done_mask,
  input logic [NCH-1:0] arrival_mask
);
  AST_DONE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_mask & ~$past(done_mask)) != '0) |-> done_irq); // R5
  AST_ARR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((arrival_mask & ~$past(arrival_mask)) != '0) |-> arrival_irq); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done_irq) && !$past(clr_done)) |-> done_irq); // R8
  AST_ARR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(arrival_irq) && !$past(clr_arrival)) |-> arrival_irq); // R8
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_done) && ((done_mask & ~$past(done_mask)) == '0)
     && $past(done_mask) == done_mask) |-> !done_irq); // R8
  AST_RANGE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ch >= CW'(NCH)) |-> (rd_val == 2'd0)); // R3
  AST_MASK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ch < CW'(NCH) && !rd_dir) |-> ((rd_val == 2'd3) == done_mask[rd_ch])); // R9
endmodule

bind mbox_state_irq mbox_state_irq_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_done(clr_done), .clr_arrival(clr_arrival),
  .rd_dir(rd_dir), .rd_ch(rd_ch), .rd_val(rd_val), .done_irq(done_irq),
  .arrival_irq(arrival_irq), .done_mask(done_mask), .arrival_mask(arrival_mask)
);

// File: tb/sim_mbox_state_irq.sv
`timescale 1ns/1ps
module sim_mbox_state_irq;
  logic clk = 0, rst_n = 0;
  logic h_we = 0, h_dir = 0, c_we = 0, c_dir = 0, clr_done = 0, clr_arrival = 0, rd_dir = 0;
  logic [2:0] h_ch = 0, c_ch = 0, rd_ch = 0;
  logic [1:0] h_val = 0, c_val = 0, rd_val;
  logic done_irq, arrival_irq;
  logic [6:0] done_mask, arrival_mask;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mbox_state_irq u0 (.*);

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(bit hwe, bit hd, int hc, int hv, bit cwe, bit cd, int cc, int cv,
                      bit cld = 0, bit cla = 0);
    h_we = hwe; h_dir = hd; h_ch = 3'(hc); h_val = 2'(hv);
    c_we = cwe; c_dir = cd; c_ch = 3'(cc); c_val = 2'(cv);
    clr_done = cld; clr_arrival = cla;
    @(negedge clk);
    h_we = 0; c_we = 0; clr_done = 0; clr_arrival = 0;
  endtask

  task automatic hw(bit d, int c, int v); step(1, d, c, v, 0, 0, 0, 0); endtask
  task automatic cw(bit d, int c, int v); step(0, 0, 0, 0, 1, d, c, v); endtask

  task automatic rd_chk(string tag, bit d, int c, int exp);
    rd_dir = d; rd_ch = 3'(c); #1;
    chk(tag, rd_val, exp);
  endtask

  task automatic t_reset;
    chk("R1 done_irq", done_irq, 0);
    chk("R1 arrival_irq", arrival_irq, 0);
    chk("R1 done_mask", done_mask, 0);
    chk("R1 arrival_mask", arrival_mask, 0);
    for (int c = 0; c < 7; c++) begin
      rd_chk("R1 send state", 0, c, 0);
      rd_chk("R1 recv state", 1, c, 0);
    end
  endtask

  task automatic t_send_flow;
    hw(0, 2, 1);
    rd_chk("R2 host NEW stored", 0, 2, 1);
    chk("R10 send NEW no arrival", arrival_irq, 0);
    cw(0, 2, 2);
    rd_chk("R2 cop RCVD stored", 0, 2, 2);
    chk("R5 no done before COMPLETE", done_irq, 0);
    cw(0, 2, 3);
    chk("R5 done on COMPLETE", done_irq, 1);
    chk("R9 done_mask bit2", done_mask, 7'h04);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 clear done", done_irq, 0);
    hw(0, 2, 3);
    chk("R7 rewrite COMPLETE no flag", done_irq, 0);
    hw(0, 2, 0);
    chk("R9 done_mask after IDLE", done_mask, 0);
    chk("R7 still clear", done_irq, 0);
  endtask

  task automatic t_recv_flow;
    cw(1, 6, 1);
    chk("R6 arrival on NEW", arrival_irq, 1);
    chk("R9 arrival_mask bit6", arrival_mask, 7'h40);
    chk("R10 recv NEW no done", done_irq, 0);
    hw(1, 6, 2);
    chk("R9 arrival_mask after RCVD", arrival_mask, 0);
    chk("R8 arrival held", arrival_irq, 1);
    hw(1, 6, 3);
    chk("R10 recv COMPLETE no done", done_irq, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 clear arrival", arrival_irq, 0);
    cw(0, 0, 1);
    chk("R10 send NEW no arrival", arrival_irq, 0);
    cw(1, 6, 0);
    rd_chk("R2 recv returned IDLE", 1, 6, 0);
    cw(1, 6, 0);
    chk("R7 rewrite IDLE no flag", arrival_irq, 0);
  endtask

  task automatic t_range;
    hw(0, 7, 3);
    chk("R3 out-of-range no done", done_irq, 0);
    chk("R3 out-of-range mask", done_mask, 0);
    cw(1, 7, 1);
    chk("R3 out-of-range no arrival", arrival_irq, 0);
    rd_chk("R3 read idx7", 0, 7, 0);
    rd_chk("R3 send ch0 untouched", 0, 0, 1);
  endtask

  task automatic t_collide;
    step(1, 0, 4, 1, 1, 0, 4, 3);
    rd_chk("R4 cop wins", 0, 4, 3);
    chk("R4 done from cop COMPLETE", done_irq, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step(1, 1, 3, 1, 1, 1, 3, 2);
    rd_chk("R4 cop wins recv", 1, 3, 2);
    chk("R4 host NEW dropped", arrival_irq, 0);
  endtask

  task automatic t_clear_race;
    step(0, 0, 0, 0, 1, 0, 5, 3, 1, 0);
    chk("R8 set beats clear", done_irq, 1);
    step(1, 1, 1, 1, 0, 0, 0, 0, 0, 1);
    chk("R8 arrival set beats clear", arrival_irq, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R8 done clears", done_irq, 0);
    chk("R8 arrival clears", arrival_irq, 0);
    chk("R9 done_mask ch4 ch5", done_mask, 7'h30);
    chk("R9 arrival_mask ch1", arrival_mask, 7'h02);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_send_flow();
    t_recv_flow();
    t_range();
    t_collide();
    t_clear_race();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule